// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Model

This block is a synchronous model of a small serial EEPROM that sits on a two-wire bus as a slave. A system clock oversamples the clock and data lines. The block finds start and stop conditions and shifts bytes in on rising clock edges. It acknowledges an address byte only when the byte names this device. The contents are 256 bytes, read back either at the current internal address or at a chosen word address.

Write data goes into an eight-byte row buffer. The array is updated only when a stop condition ends the transfer. The update then waits for a timed internal cycle of `WR_CYCLES` system clocks. While that cycle runs, the block ignores every address byte, so a master can keep sending the address until it sees an acknowledge. A write-protect input suppresses storing. The data line is open drain: the block only ever pulls it low.

Top module: `ee_serial_slave`

## Requirements
- R1: An address byte is acknowledged only when bits 7..4 are 1010 and bits 3..1 equal `chip_sel_i`. Bit 0 selects the direction: 1 = read, 0 = write.
- R2: After a non-matching address byte, the block acknowledges no further byte until the next start condition.
- R3: An accepted byte is acknowledged by holding `sda_pull_o` high through the ninth clock pulse.
- R4: A falling data edge while the clock is high is a start condition, and it always restarts address reception. A rising data edge while the clock is high is a stop condition, and it returns the block to idle.
- R5: In a write transfer, the byte after the address is the word address and is acknowledged. Each following data byte is acknowledged. A single data byte followed by stop is stored at the word address.
- R6: Successive data bytes of one write transfer go to successive addresses, but only address bits 2..0 advance. A ninth byte therefore overwrites the first byte of the same eight-byte row.
- R7: Write data is stored only after a stop. A start condition that arrives before the stop discards the buffered data and starts no write cycle.
- R8: For `WR_CYCLES` clocks after a stop that ends a write carrying data, no address byte is acknowledged. After that time, address bytes are acknowledged again and the new data can be read.
- R9: While `wp_i` is high at the stop, the data is not stored and no write cycle starts.
- R10: A read address byte returns data starting at the internal address, which is the address after the last byte written or read.
- R11: During a read, the address increments after each byte across the whole array, wrapping from 0xFF to 0x00.
- R12: A master non-acknowledge ends a read. The block then releases the data line and ignores the bus until the next start.
- R13: After reset, the array holds zeros, the internal address is 0x00 and `sda_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (the wired result) |
| chip_sel_i | input | 3 | Hardwired device select value |
| wp_i | input | 1 | Write protect, active high |
| sda_pull_o | output | 1 | When high, the data line is pulled low |

## Verification
On every cycle, the assertions check several rules: a start condition always lands in address reception with the data line released, and an address byte seen during the write timer is never acknowledged. They also check that the timer starts only on the cycle after a stop, that write protect prevents it from starting, and that write addresses stay inside the row set by the word address. Only the bench scenarios can show the data behaviour. That covers which values end up in the array, the row wrap and overwrite, data discarded on a restart, the poll count needed before an acknowledge, address continuity across reads and the read wrap at 0xFF. The same holds for address matching, which the bench sweeps over all 128 address values.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDAT,
    ST_RDAT
  } ee_state_e;

  localparam logic [3:0] EE_DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  logic scl_s, sda_s, scl_p, sda_p;
  assign {scl_s, sda_s} = synced;
  assign {scl_p, sda_p} = prev_q;

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s && !scl_p;
  assign scl_fall_o = !scl_s && scl_p;
  assign start_o    = scl_s && scl_p && sda_p && !sda_s;
  assign stop_o     = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/ee_write_cycle.sv
module ee_write_cycle #(
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stage_we_i,
  input  logic [PAGE_W-1:0]        stage_idx_i,
  input  logic [7:0]               stage_data_i,
  input  logic                     clear_i,
  input  logic                     go_i,
  output logic                     busy_o,
  output logic                     commit_o,
  output logic [(1<<PAGE_W)-1:0]   mask_o,
  output logic [(1<<PAGE_W)*8-1:0] data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TMR_W      = $clog2(WR_CYCLES + 1);

  logic [TMR_W-1:0]      tmr_q;
  logic                  busy_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            buf_q [PAGE_BYTES];

  assign commit_o = busy_q && (tmr_q == '0);
  assign busy_o   = busy_q;
  assign mask_o   = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      tmr_q  <= TMR_W'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= '0;
    end else if (commit_o || (clear_i && !go_i && !busy_q)) begin
      mask_q <= '0;
    end else if (stage_we_i) begin
      mask_q[stage_idx_i] <= 1'b1;
      buf_q[stage_idx_i]  <= stage_data_i;
    end
  end

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_out
    assign data_o[b*8 +: 8] = buf_q[b];
  end

  // R8: timer restarts only from idle
  assert_go_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] row_i,
  input  logic [(1<<PAGE_W)-1:0]   mask_i,
  input  logic [(1<<PAGE_W)*8-1:0] data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        if (mask_i[b]) mem_q[{row_i, PAGE_W'(b)}] <= data_i[b*8 +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ee_serial_slave.sv
module ee_serial_slave
  import ee_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  ee_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  ee_state_e         st_q;
  logic [3:0]        bit_cnt_q;
  logic              ack_ph_q;
  logic [7:0]        shreg_q;
  logic [7:0]        out_q;
  logic              pull_q;
  logic              rd_q;
  logic              mack_q;
  logic              got_data_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [ROW_W-1:0]  row_q;

  logic                    busy, commit;
  logic [PAGE_BYTES-1:0]   cmask;
  logic [PAGE_BYTES*8-1:0] cdata;
  logic [7:0]              rd_data;

  logic byte_done, ack_done, dev_match, stage_we, go, clear;

  assign byte_done = scl_fall && !start_evt && !stop_evt &&
                     (bit_cnt_q == 4'd8) && !ack_ph_q;
  assign ack_done  = scl_fall && !start_evt && !stop_evt &&
                     (bit_cnt_q == 4'd8) && ack_ph_q;
  assign dev_match = (shreg_q[7:4] == EE_DEV_CODE) && (shreg_q[3:1] == chip_sel_i);
  assign stage_we  = byte_done && (st_q == ST_WDAT);
  assign go        = stop_evt && (st_q == ST_WDAT) && got_data_q && !wp_i;
  assign clear     = start_evt || stop_evt;

  ee_write_cycle #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) i_wcyc (
    .clk_i, .rst_ni,
    .stage_we_i(stage_we), .stage_idx_i(cur_addr_q[PAGE_W-1:0]),
    .stage_data_i(shreg_q), .clear_i(clear), .go_i(go),
    .busy_o(busy), .commit_o(commit), .mask_o(cmask), .data_o(cdata)
  );

  ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_array (
    .clk_i, .rst_ni,
    .commit_i(commit), .row_i(row_q), .mask_i(cmask), .data_i(cdata),
    .rd_addr_i(cur_addr_q), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      ack_ph_q   <= 1'b0;
      shreg_q    <= '0;
      out_q      <= '0;
      pull_q     <= 1'b0;
      rd_q       <= 1'b0;
      mack_q     <= 1'b0;
      got_data_q <= 1'b0;
      cur_addr_q <= '0;
      row_q      <= '0;
    end else if (start_evt) begin
      st_q       <= ST_DEV;
      bit_cnt_q  <= '0;
      ack_ph_q   <= 1'b0;
      pull_q     <= 1'b0;
      got_data_q <= 1'b0;
    end else if (stop_evt) begin
      st_q       <= ST_IDLE;
      ack_ph_q   <= 1'b0;
      pull_q     <= 1'b0;
      got_data_q <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (st_q == ST_RDAT) begin
          if (bit_cnt_q != 4'd8) bit_cnt_q <= bit_cnt_q + 4'd1;
          else begin
            ack_ph_q <= 1'b1;
            mack_q   <= !sda_s;
          end
        end else if (bit_cnt_q != 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
      end else if (scl_fall) begin
        if (st_q == ST_RDAT) begin
          if (ack_ph_q) begin
            ack_ph_q <= 1'b0;
            if (mack_q) begin
              bit_cnt_q  <= '0;
              out_q      <= rd_data;
              pull_q     <= !rd_data[7];
              cur_addr_q <= cur_addr_q + 1'b1;
            end else begin
              st_q   <= ST_IDLE;
              pull_q <= 1'b0;
            end
          end else if (bit_cnt_q == 4'd8) begin
            pull_q <= 1'b0;
          end else if (bit_cnt_q != 4'd0) begin
            out_q  <= {out_q[6:0], 1'b0};
            pull_q <= !out_q[6];
          end
        end else if (byte_done) begin
          case (st_q)
            ST_DEV: begin
              if (dev_match && !busy) begin
                ack_ph_q <= 1'b1;
                pull_q   <= 1'b1;
                rd_q     <= shreg_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
            ST_WORD: begin
              ack_ph_q   <= 1'b1;
              pull_q     <= 1'b1;
              cur_addr_q <= shreg_q[ADDR_W-1:0];
              row_q      <= shreg_q[ADDR_W-1:PAGE_W];
            end
            default: begin
              ack_ph_q   <= 1'b1;
              pull_q     <= 1'b1;
              got_data_q <= 1'b1;
              cur_addr_q <= {cur_addr_q[ADDR_W-1:PAGE_W],
                             cur_addr_q[PAGE_W-1:0] + PAGE_W'(1)};
            end
          endcase
        end else if (ack_done) begin
          ack_ph_q  <= 1'b0;
          bit_cnt_q <= '0;
          pull_q    <= 1'b0;
          if (st_q == ST_DEV) begin
            if (rd_q) begin
              st_q       <= ST_RDAT;
              out_q      <= rd_data;
              pull_q     <= !rd_data[7];
              cur_addr_q <= cur_addr_q + 1'b1;
            end else begin
              st_q <= ST_WORD;
            end
          end else if (st_q == ST_WORD) begin
            st_q <= ST_WDAT;
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;

  // R4: a start always leads to address reception with the line released
  assert_start_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (st_q == ST_DEV) && !sda_pull_o);

  // R8: no acknowledge of an address byte while the write timer runs
  assert_no_ack_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && st_q == ST_DEV && busy) |=> !sda_pull_o);

  // R7: write timer starts only on the cycle after a stop
  assert_cycle_after_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_evt));

  // R9: protected stop never starts the timer
  assert_wp_no_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt && wp_i && !busy) |=> !busy);

  // R6: write addresses stay inside the row given by the word address
  assert_row_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WDAT) |-> (cur_addr_q[ADDR_W-1:PAGE_W] == row_q));
endmodule

// File: tb/test_ee_serial_slave.sv
module test_ee_serial_slave;
  localparam int WR_CYC = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] cs = 3'd5;
  logic       wp = 1'b0;
  logic       sda_pull;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  ee_serial_slave #(.WR_CYCLES(WR_CYC)) i_ee_serial_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_sel_i(cs), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [7:0] mem_ref [256];
  logic [7:0] cur_ref = 8'h00;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(4);
    scl_m = 1'b1; w(4);
    sda_m = 1'b0; w(4);
    scl_m = 1'b0; w(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(4);
    scl_m = 1'b1; w(4);
    sda_m = 1'b1; w(8);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; w(6);
    scl_m = 1'b1; w(4);
    s = sda_bus; w(4);
    scl_m = 1'b0; w(2);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] c, input bit rd);
    return {4'b1010, c, rd};
  endfunction

  // poll with address byte until acknowledged; returns poll count
  task automatic poll(output int n);
    bit a;
    n = 0;
    do begin
      bus_start();
      wr_byte(dev(cs, 0), a);
      bus_stop();
      n++;
    end while (!a && n < 10);
  endtask

  task automatic page_write(input logic [7:0] wa, input int n, input logic [7:0] seed,
                            input string tag);
    bit a;
    logic [7:0] d;
    bus_start();
    wr_byte(dev(cs, 0), a); chk(a, {tag, " dev ack"}, a, 1);
    wr_byte(wa, a);         chk(a, {tag, " word ack R5"}, a, 1);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 37);
      wr_byte(d, a);
      chk(a, {tag, " data ack R3"}, a, 1);
      if (!wp) mem_ref[{wa[7:3], 3'(wa[2:0] + 3'(i))}] = d;
    end
    cur_ref = {wa[7:3], 3'(wa[2:0] + 3'(n))};
    bus_stop();
  endtask

  task automatic seq_read(input bit random, input logic [7:0] wa, input int n,
                          input string tag);
    bit a;
    logic [7:0] d;
    bus_start();
    if (random) begin
      wr_byte(dev(cs, 0), a);
      wr_byte(wa, a);
      cur_ref = wa;
      bus_start();
    end
    wr_byte(dev(cs, 1), a);
    chk(a, {tag, " read dev ack R1"}, a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(d === mem_ref[cur_ref], {tag, " data"}, d, mem_ref[cur_ref]);
      cur_ref = cur_ref + 8'd1;
    end
    w(4);
    chk(sda_pull == 1'b0, {tag, " release after nack R12"}, sda_pull, 0);
    bus_stop();
  endtask

  initial begin
    bit a;
    int np;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) mem_ref[i] = 8'h00;
    w(5);
    chk(sda_pull == 1'b0, "reset pull R13", sda_pull, 0);
    rst_n = 1'b1;
    w(5);

    // R13: current read from reset gives address 0 contents (zero)
    seq_read(0, 8'h00, 2, "R13 reset read");

    // R1: sweep every 7-bit address value
    for (int v = 0; v < 128; v++) begin
      bus_start();
      wr_byte(8'(v << 1), a);
      bus_stop();
      chk(a == (v[6:3] == 4'hA && v[2:0] == cs), "R1 address sweep", a,
          (v[6:3] == 4'hA && v[2:0] == cs));
    end
    cs = 3'd2;
    bus_start(); wr_byte(dev(3'd2, 0), a); bus_stop();
    chk(a, "R1 new chip select", a, 1);
    bus_start(); wr_byte(dev(3'd5, 0), a); bus_stop();
    chk(!a, "R1 old chip select", a, 0);

    // R2: non-matching address then more bytes: no ack
    bus_start();
    wr_byte(dev(3'd6, 0), a);
    wr_byte(8'h00, a); chk(!a, "R2 ignored word", a, 0);
    wr_byte(8'h5A, a); chk(!a, "R2 ignored data", a, 0);
    bus_stop();

    // R5/R8: byte write, busy polling
    page_write(8'h40, 1, 8'hC3, "R5 byte");
    poll(np);
    chk(np >= 2, "R8 first poll nack", np, 2);
    chk(np < 10, "R8 ack after cycle", np, 2);
    seq_read(1, 8'h40, 1, "R5 readback");

    // R6: partial page from offset 3
    page_write(8'h13, 3, 8'h11, "R6 partial");
    poll(np);
    chk(np >= 2, "R8 busy after page", np, 2);
    seq_read(1, 8'h10, 8, "R6 partial row");
    // R6: ten bytes from offset 5 wrap and overwrite in row 0x28
    page_write(8'h2D, 10, 8'h80, "R6 wrap");
    poll(np);
    seq_read(1, 8'h28, 8, "R6 wrap row");
    chk(mem_ref[8'h30] === 8'h00, "R6 next row untouched ref", mem_ref[8'h30], 0);
    seq_read(1, 8'h30, 1, "R6 next row");

    // R10: write then current-address read follows last written byte
    page_write(8'hFE, 1, 8'h77, "R10 wr");
    poll(np);
    seq_read(0, 8'h00, 3, "R10 current"); // FF, 00, 01

    // R7: restart before stop discards data, no busy
    bus_start();
    wr_byte(dev(cs, 0), a);
    wr_byte(8'h60, a);
    wr_byte(8'hEE, a);
    bus_start();
    wr_byte(dev(cs, 0), a);
    chk(a, "R7 no cycle after restart", a, 1);
    bus_stop();
    seq_read(1, 8'h60, 1, "R7 discarded");

    // R9: protected write not stored, no busy
    wp = 1'b1;
    page_write(8'h40, 2, 8'h99, "R9 wp");
    poll(np);
    chk(np == 1, "R9 no write cycle", np, 1);
    wp = 1'b0;
    seq_read(1, 8'h40, 2, "R9 unchanged");

    // R11: sequential read across the whole array and wrap
    seq_read(1, 8'hF8, 264, "R11 wrap");
    // R10: continuing current read after long sequence
    seq_read(0, 8'h00, 1, "R10 after wrap");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule